// File: doc/BRIEF.md
# Oscillator Mode Clock Controller

This block sits between the primary oscillator input and the rest of the chip. A static mode field and a ratio field are captured while reset is held. From them the block builds the system clock, either the raw oscillator clock or a divided version of it. It also decides what the secondary oscillator pin does. The pin can carry a quarter-rate clock for test or for synchronising other logic, it can serve as one general-purpose I/O bit, or it can be released so that it floats.

In the crystal modes the block does not report the clock as usable until a start-up counter has run out after reset or after a wake event. In the external-clock modes the clock is reported usable as soon as reset is released, and a wake event leaves that flag alone. The mode and ratio inputs are ignored once reset is released, so they cannot change while the chip is running.

Mode encoding (`osc_mode`): 0 crystal-low, 1 crystal-high, 2 external clock with clock out, 3 external clock with I/O, 4 multiplied external clock with clock out, 5 multiplied external clock with I/O. Codes 6 and 7 behave as crystal-high.

Top module: `osc_clk_ctrl`

## Requirements
- R1: In modes 0, 1, 2, 3, 6 and 7, `div_sel` selects the system clock from the oscillator clock by its value: 0 passes it through, 1 divides by 2, 2 divides by 3, 3 divides by 4. The divide-by-2 and divide-by-4 outputs are low after reset and first rise on the 1st and 2nd oscillator rising edge after release.
- R2: The divide-by-3 output has a 50 percent duty cycle. It is high for one and a half oscillator periods. It rises on the 3rd rising edge after release and falls on the falling edge that follows the next rising edge.
- R3: In modes 4 and 5 the system clock equals the oscillator clock whatever `div_sel` holds.
- R4: In modes 2 and 4, `pin_oe` is 1 and `pin_out` carries the oscillator clock divided by 4. It is low after release, high after the 2nd and 3rd rising edges, and low again after the 4th.
- R5: In modes 3 and 5 the pin is general-purpose I/O. A rising edge with `reg_we` high loads `reg_wdata[0]` as the data-out bit and `reg_wdata[1]` as the output-enable bit. `pin_oe` follows the enable bit, `pin_out` follows the data bit, and `reg_rdata[1:0]` reads both back.
- R6: `reg_rdata[2]` shows `pin_in` after two oscillator rising edges of synchronisation.
- R7: In modes 0, 1, 6 and 7, `pin_oe` is 0, so the pin is left undriven.
- R8: In modes 0, 1, 6 and 7, `clk_ready` is 0 during reset. It rises only after `STARTUP` rising edges (default 1024) have been counted following reset release.
- R9: In modes 0, 1, 6 and 7, a rising edge with `wake` high clears `clk_ready` and restarts the count. The flag returns after `STARTUP` further edges.
- R10: In modes 2 to 5, `clk_ready` is 1 whenever reset is released, and `wake` has no effect on it.
- R11: `osc_mode` and `div_sel` are captured only on rising edges while `rst_n` is low. Changes made after release do not affect any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| wake | input | 1 | Wake-from-sleep pulse; restarts the crystal start-up count |
| osc_mode | input | 3 | Oscillator mode code |
| div_sel | input | 2 | Postscaler ratio select |
| sys_clk | output | 1 | System clock after the postscaler |
| clk_ready | output | 1 | System clock is usable |
| pin_out | output | 1 | Secondary pin output value |
| pin_oe | output | 1 | Secondary pin output enable |
| pin_in | input | 1 | Secondary pin input value |
| reg_we | input | 1 | Write strobe for the pin register |
| reg_wdata | input | 2 | Bit 0 data out, bit 1 output enable |
| reg_rdata | output | 3 | Bit 0 data out, bit 1 output enable, bit 2 synchronised pin input |

## Verification
The postscaler is sampled twice per oscillator period, once before and once after the falling edge, at each of the four ratios. This separates a pass-through clock from a divided one, and it shows the half-period step that only the divide-by-3 output has. The pin is run in each of its three roles, including register writes that turn the output enable both on and off. The ready flag is checked through a full crystal start-up, a wake part way through a run, and a wake in external mode, so a skipped count, a missing restart or a wrongly applied wait each give a different mismatch. Mode and ratio inputs are changed after release to show that the captured configuration holds.

// File: rtl/osc_clk_ctrl.sv
`timescale 1ns/1ps
module osc_clk_ctrl #(
  parameter int STARTUP = 1024,
  parameter int SYNC    = 2
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       wake,
  input  logic [2:0] osc_mode,
  input  logic [1:0] div_sel,
  output logic       sys_clk,
  output logic       clk_ready,
  output logic       pin_out,
  output logic       pin_oe,
  input  logic       pin_in,
  input  logic       reg_we,
  input  logic [1:0] reg_wdata,
  output logic [2:0] reg_rdata
);
  localparam logic [2:0] M_EXT   = 3'd2;
  localparam logic [2:0] M_EXTIO = 3'd3;
  localparam logic [2:0] M_MUL   = 3'd4;
  localparam logic [2:0] M_MULIO = 3'd5;
  localparam int CW = (STARTUP > 1) ? $clog2(STARTUP) : 1;
  localparam logic [CW-1:0] SU_LAST = CW'(STARTUP - 1);

  logic [2:0] mode_q;
  logic [1:0] sel_q;
  logic ext_q, xtal_q, mul_q, gpio_q, clkout_q;

  always_ff @(posedge clk_osc)
    if (!rst_n) begin
      mode_q <= osc_mode;
      sel_q  <= div_sel;
    end

  assign ext_q    = (mode_q >= M_EXT) && (mode_q <= M_MULIO);
  assign xtal_q   = !ext_q;
  assign mul_q    = (mode_q == M_MUL) || (mode_q == M_MULIO);
  assign gpio_q   = (mode_q == M_EXTIO) || (mode_q == M_MULIO);
  assign clkout_q = (mode_q == M_EXT) || (mode_q == M_MUL);

  logic [1:0] cnt4;
  logic [1:0] c3;
  logic p3, n3, div_clk;

  always_ff @(posedge clk_osc or negedge rst_n)
    if (!rst_n) begin
      cnt4 <= '0;
      c3   <= '0;
      p3   <= 1'b0;
    end else begin
      cnt4 <= cnt4 + 2'd1;
      c3   <= (c3 == 2'd2) ? 2'd0 : c3 + 2'd1;
      p3   <= (c3 == 2'd2);
    end

  always_ff @(negedge clk_osc or negedge rst_n)
    if (!rst_n) n3 <= 1'b0;
    else        n3 <= p3;

  always_comb
    case (sel_q)
      2'd0:    div_clk = clk_osc;
      2'd1:    div_clk = cnt4[0];
      2'd2:    div_clk = p3 | n3;
      default: div_clk = cnt4[1];
    endcase

  assign sys_clk = mul_q ? clk_osc : div_clk;

  logic [CW-1:0] su_cnt;
  logic x_rdy;

  always_ff @(posedge clk_osc or negedge rst_n)
    if (!rst_n) begin
      su_cnt <= '0;
      x_rdy  <= 1'b0;
    end else if (wake) begin
      su_cnt <= '0;
      x_rdy  <= 1'b0;
    end else if (!x_rdy) begin
      if (su_cnt == SU_LAST) x_rdy  <= 1'b1;
      else                   su_cnt <= su_cnt + 1'b1;
    end

  assign clk_ready = rst_n & (ext_q | x_rdy);

  logic g_oe, g_do;
  logic [SYNC-1:0] din_s;

  always_ff @(posedge clk_osc or negedge rst_n)
    if (!rst_n) begin
      g_oe  <= 1'b0;
      g_do  <= 1'b0;
      din_s <= '0;
    end else begin
      din_s <= {din_s[SYNC-2:0], pin_in};
      if (reg_we) begin
        g_do <= reg_wdata[0];
        g_oe <= reg_wdata[1];
      end
    end

  assign pin_oe    = clkout_q | (gpio_q & g_oe);
  assign pin_out   = clkout_q ? cnt4[1] : (gpio_q & g_do);
  assign reg_rdata = {din_s[SYNC-1], g_oe, g_do};

  // R7
  pin_float_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    xtal_q |-> !pin_oe);

  // R8
  ready_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (xtal_q && !clk_ready && !wake && su_cnt != SU_LAST) |=> !clk_ready);

  // R9
  wake_drop_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (xtal_q && wake) |=> !clk_ready);

  // R10
  ext_ready_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ext_q |-> clk_ready);

  // R5
  gpio_wr_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (gpio_q && reg_we) |=> (pin_oe == $past(reg_wdata[1])));

  // R11
  cfg_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    1'b1 |=> ($stable(mode_q) && $stable(sel_q)));
endmodule

// File: tb/osc_clk_ctrl_tb.sv
`timescale 1ns/1ps
module osc_clk_ctrl_tb;
  localparam int P  = 10;
  localparam int SU = 1024;

  logic clk = 1'b0, rst_n = 1'b0, wake = 1'b0, pin_in = 1'b0, reg_we = 1'b0;
  logic [2:0] osc_mode = 3'd0;
  logic [1:0] div_sel = 2'd0, reg_wdata = 2'd0;
  logic sys_clk, clk_ready, pin_out, pin_oe;
  logic [2:0] reg_rdata;

  always #(P/2) clk = ~clk;

  osc_clk_ctrl #(.STARTUP(SU), .SYNC(2)) u_dut (
    .clk_osc(clk), .rst_n(rst_n), .wake(wake), .osc_mode(osc_mode),
    .div_sel(div_sel), .sys_clk(sys_clk), .clk_ready(clk_ready),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  typedef struct {
    logic s, po, oe, rd;
    string ts, tp, tr;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  int k, last_wake, m_mode, m_sel;
  logic g_oe, g_do;
  string extra;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input item_t it);
    check(sys_clk === it.s, {it.ts, extra, " sys_clk"}, int'(sys_clk), int'(it.s));
    check(pin_oe === it.oe, {it.tp, extra, " pin_oe"}, int'(pin_oe), int'(it.oe));
    if (it.oe)
      check(pin_out === it.po, {it.tp, extra, " pin_out"}, int'(pin_out), int'(it.po));
    check(clk_ready === it.rd, {it.tr, extra, " clk_ready"}, int'(clk_ready), int'(it.rd));
  endtask

  initial forever begin
    @(posedge clk);
    #(P/4);
    if (q.size() > 0) compare(q.pop_front());
    #(P/2);
    if (q.size() > 0) compare(q.pop_front());
  end

  function automatic bit is_ext(input int m);
    return m >= 2 && m <= 5;
  endfunction

  task automatic push_cycle();
    item_t a, b;
    bit mul = (m_mode == 4 || m_mode == 5);
    bit gp  = (m_mode == 3 || m_mode == 5);
    bit co  = (m_mode == 2 || m_mode == 4);
    a.ts = mul ? "R3" : (m_sel == 2 ? "R2" : "R1");
    if (mul || m_sel == 0) begin a.s = 1'b1; b.s = 1'b0; end
    else if (m_sel == 1)   begin a.s = k[0]; b.s = k[0]; end
    else if (m_sel == 3)   begin a.s = (k % 4) >= 2; b.s = (k % 4) >= 2; end
    else begin
      a.s = (k % 3 == 0) || (k > 1 && (k - 1) % 3 == 0);
      b.s = (k % 3 == 0);
    end
    if (co)      begin a.oe = 1'b1; a.po = (k % 4) >= 2; a.tp = "R4"; end
    else if (gp) begin a.oe = g_oe; a.po = g_do; a.tp = "R5"; end
    else         begin a.oe = 1'b0; a.po = 1'b0; a.tp = "R7"; end
    if (is_ext(m_mode)) begin a.rd = 1'b1; a.tr = "R10"; end
    else begin
      a.rd = (k - last_wake) >= SU;
      a.tr = (last_wake > 0) ? "R9" : "R8";
    end
    b.oe = a.oe; b.po = a.po; b.rd = a.rd; b.tp = a.tp; b.tr = a.tr; b.ts = a.ts;
    q.push_back(a);
    q.push_back(b);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      k++;
      if (reg_we) begin g_do = reg_wdata[0]; g_oe = reg_wdata[1]; end
      if (wake) last_wake = k;
      push_cycle();
      #1;
      reg_we = 1'b0;
      wake = 1'b0;
    end
  endtask

  task automatic start(input int mode, input int sel);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    extra = "";
    osc_mode = 3'(mode);
    div_sel = 2'(sel);
    m_mode = mode; m_sel = sel;
    g_oe = 1'b0; g_do = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(clk_ready === 1'b0, "R8 ready in reset", int'(clk_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    last_wake = 0;
  endtask

  task automatic wr(input logic oe, input logic d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = {oe, d};
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1'b1;
  endtask

  initial begin
    #(P * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    start(0, 0);
    step(SU + 16);
    start(1, 1);
    step(40);
    pulse_wake();
    step(SU + 12);
    start(2, 2);
    step(30);
    pulse_wake();
    step(12);
    start(3, 3);
    step(8);
    wr(1'b1, 1'b1);
    step(4);
    check(reg_rdata[1:0] === 2'b11, "R5 readback", int'(reg_rdata[1:0]), 3);
    wr(1'b1, 1'b0);
    step(4);
    wr(1'b0, 1'b1);
    step(4);
    check(reg_rdata[1:0] === 2'b01, "R5 readback", int'(reg_rdata[1:0]), 1);
    @(negedge clk);
    pin_in = 1'b1;
    step(1);
    check(reg_rdata[2] === 1'b0, "R6 one edge", int'(reg_rdata[2]), 0);
    step(1);
    check(reg_rdata[2] === 1'b1, "R6 two edges", int'(reg_rdata[2]), 1);
    @(negedge clk);
    pin_in = 1'b0;
    step(2);
    check(reg_rdata[2] === 1'b0, "R6 fall", int'(reg_rdata[2]), 0);
    @(negedge clk);
    osc_mode = 3'd0;
    div_sel = 2'd1;
    extra = " R11";
    step(16);
    start(4, 2);
    step(20);
    start(5, 1);
    step(4);
    wr(1'b1, 1'b1);
    step(8);
    start(7, 1);
    step(SU + 8);
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule